// File: doc/BRIEF.md
# Fixed-Latency Trigger Hit Packer

This block builds a fixed-length trigger frame once every three reference-clock cycles. The frame carries at most two detector hits, and each hit is a 2-bit timing value joined to a 5-bit position. At every frame boundary the block samples a hit count and two hit records. In the same edge it produces a 24-bit frame word, raises a one-cycle valid pulse and loads an 8-bit lane. Over the following three cycles that lane streams the frame out, most significant byte first. The latency from sampling to the last byte leaving is therefore always three reference cycles.

The frame begins with a count descriptor: one data bit sent three times, which a receiver can decode by majority vote. The two hit slots follow, then an even-parity bit over both slots, then a flag that separates "one hit" from "no hit". Zero padding completes the 24 bits. When more than two hits are offered, the first two are sent and an overflow flag is raised for that frame.

Top module: `trig_hit_packer`

## Requirements
- R1: Counting from the first rising edge after reset is released, `frame_valid_o` is high for exactly one cycle after edge 3, 6, 9 and so on, and is low at all other times.
- R2: The inputs are sampled only at a frame-boundary edge. Between two valid pulses, `frame_o` and `overflow_o` keep their values whatever the inputs do.
- R3: When `hit_count_i` is greater than 2, only hit 0 and hit 1 are packed, and `overflow_o` is 1 for that frame. Otherwise `overflow_o` is 0. `overflow_o` holds its value until the next frame.
- R4: Descriptor bits 23, 22 and 21 are all equal. They are 1 when `hit_count_i` is 2 or more, and 0 otherwise.
- R5: Bits 20..14 hold hit 0 and bits 13..7 hold hit 1. Each slot is arranged as {time[1:0], pos[4:0]}, with time in the upper two bits.
- R6: An unused hit slot is all zeros. Slot 0 is unused when the count is 0. Slot 1 is unused when the count is below 2.
- R7: Bit 6 is an even-parity bit over bits 20..7. The XOR of bits 20..6 is therefore 0.
- R8: Bit 5 is 1 when `hit_count_i` is 1 or more, and 0 otherwise. Bits 4..0 are always 0.
- R9: `ser_o` gives frame bits 23..16 in the cycle in which `frame_valid_o` is high. It gives bits 15..8 in the next cycle and bits 7..0 in the cycle after that.
- R10: While reset is asserted, every output is 0. Releasing reset restarts the frame phase, so the first frame appears after edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_count_i | input | 3 | Number of hits offered in the current window |
| hit0_time_i | input | 2 | Timing of the first hit |
| hit0_pos_i | input | 5 | Position of the first hit |
| hit1_time_i | input | 2 | Timing of the second hit |
| hit1_pos_i | input | 5 | Position of the second hit |
| frame_o | output | 24 | Last frame built |
| frame_valid_o | output | 1 | One-cycle pulse when a new frame appears |
| overflow_o | output | 1 | More than two hits were offered for the current frame |
| ser_o | output | 8 | Byte lane carrying the current frame, most significant byte first |

## Verification
The bench drives junk inputs (count 7, all fields set to one) between boundaries. A design that sampled on every cycle would then change `frame_o` or `overflow_o` in the middle of a frame, or would flag overflow when it should not. Counts of 0, 1, 2, 3 and 7 cover the descriptor and the slot-zeroing rules. Across those counts, a design that mixed up the one-hit and no-hit cases would send a stale slot or set the wrong occupancy bit. Hit patterns with odd and even numbers of ones catch an inverted or misplaced parity bit. A reset in the middle of a run checks that the phase restarts and does not carry on from the old count, which would make the first pulse appear early.

// File: rtl/trig_pack_pkg.sv
package trig_pack_pkg;
   localparam int unsigned TP_TIME_W    = 2;
   localparam int unsigned TP_POS_W     = 5;
   localparam int unsigned TP_LANE_W    = 8;
   localparam int unsigned TP_FRAME_CYC = 3;
   localparam int unsigned TP_REP       = 3;
   localparam int unsigned TP_CNT_W     = 3;

   function automatic int unsigned tp_clog2(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return (r == 0) ? 1 : r;
   endfunction
endpackage

// File: rtl/trig_phase_ctr.sv
module trig_phase_ctr #(
   parameter int unsigned FRAME_CYC = 3,
   localparam int unsigned PH_W = trig_pack_pkg::tp_clog2(FRAME_CYC)
) (
   input  logic clk,
   input  logic rst_n,
   output logic boundary_o
);
   logic [PH_W-1:0] ph_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q <= '0;
      end else if (ph_q == PH_W'(FRAME_CYC - 1)) begin
         ph_q <= '0;
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end

   assign boundary_o = (ph_q == PH_W'(FRAME_CYC - 1));
endmodule

// File: rtl/trig_frame_build.sv
module trig_frame_build #(
   parameter int unsigned TIME_W  = 2,
   parameter int unsigned POS_W   = 5,
   parameter int unsigned REP     = 3,
   parameter int unsigned CNT_W   = 3,
   parameter int unsigned FRAME_W = 24,
   parameter bit          ODD_PAR = 1'b0,
   localparam int unsigned HIT_W  = TIME_W + POS_W,
   localparam int unsigned BODY_W = REP + 2 * HIT_W + 2,
   localparam int unsigned PAD_W  = FRAME_W - BODY_W
) (
   input  logic [CNT_W-1:0]   hit_count_i,
   input  logic [TIME_W-1:0]  h0_time_i,
   input  logic [POS_W-1:0]   h0_pos_i,
   input  logic [TIME_W-1:0]  h1_time_i,
   input  logic [POS_W-1:0]   h1_pos_i,
   output logic [FRAME_W-1:0] frame_o,
   output logic               ovf_o
);
   logic             pair;
   logic             any;
   logic [REP-1:0]   desc;
   logic [HIT_W-1:0] slot0;
   logic [HIT_W-1:0] slot1;
   logic             par;
   logic [BODY_W-1:0] body;

   assign pair  = (hit_count_i >= CNT_W'(2));
   assign any   = (hit_count_i != '0);
   assign ovf_o = (hit_count_i >  CNT_W'(2));

   for (genvar r = 0; r < REP; r++) begin : g_rep
      assign desc[r] = pair;
   end

   assign slot0 = any  ? {h0_time_i, h0_pos_i} : '0;
   assign slot1 = pair ? {h1_time_i, h1_pos_i} : '0;

   if (ODD_PAR) begin : g_odd
      assign par = ~(^{slot0, slot1});
   end else begin : g_even
      assign par = ^{slot0, slot1};
   end

   assign body = {desc, slot0, slot1, par, any};

   if (PAD_W > 0) begin : g_pad
      assign frame_o = {body, {PAD_W{1'b0}}};
   end else begin : g_nopad
      assign frame_o = body;
   end
endmodule

// File: rtl/trig_lane_ser.sv
module trig_lane_ser #(
   parameter int unsigned FRAME_W = 24,
   parameter int unsigned LANE_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [FRAME_W-1:0] frame_i,
   output logic [LANE_W-1:0]  lane_o
);
   logic [FRAME_W-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load_i) begin
         sh_q <= frame_i;
      end else begin
         sh_q <= {sh_q[FRAME_W-LANE_W-1:0], {LANE_W{1'b0}}};
      end
   end

   assign lane_o = sh_q[FRAME_W-1 -: LANE_W];
endmodule

// File: rtl/trig_hit_packer.sv
module trig_hit_packer #(
   parameter int unsigned TIME_W    = trig_pack_pkg::TP_TIME_W,
   parameter int unsigned POS_W     = trig_pack_pkg::TP_POS_W,
   parameter int unsigned LANE_W    = trig_pack_pkg::TP_LANE_W,
   parameter int unsigned FRAME_CYC = trig_pack_pkg::TP_FRAME_CYC,
   parameter int unsigned REP       = trig_pack_pkg::TP_REP,
   parameter int unsigned CNT_W     = trig_pack_pkg::TP_CNT_W,
   parameter bit          ODD_PAR   = 1'b0,
   localparam int unsigned FRAME_W  = FRAME_CYC * LANE_W,
   localparam int unsigned HIT_W    = TIME_W + POS_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CNT_W-1:0]   hit_count_i,
   input  logic [TIME_W-1:0]  hit0_time_i,
   input  logic [POS_W-1:0]   hit0_pos_i,
   input  logic [TIME_W-1:0]  hit1_time_i,
   input  logic [POS_W-1:0]   hit1_pos_i,
   output logic [FRAME_W-1:0] frame_o,
   output logic               frame_valid_o,
   output logic               overflow_o,
   output logic [LANE_W-1:0]  ser_o
);
   if (FRAME_W < REP + 2 * HIT_W + 2) begin : g_bad_frame
      $error("trig_hit_packer: frame too small for two hits");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("trig_hit_packer: count width below 2");
   end
   if (FRAME_CYC < 2) begin : g_bad_cyc
      $error("trig_hit_packer: frame must span at least two cycles");
   end

   logic               boundary;
   logic [FRAME_W-1:0] frame_d;
   logic               ovf_d;
   logic [FRAME_W-1:0] frame_q;
   logic               valid_q;
   logic               ovf_q;

   trig_phase_ctr #(.FRAME_CYC(FRAME_CYC)) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .boundary_o (boundary)
   );

   trig_frame_build #(
      .TIME_W (TIME_W), .POS_W (POS_W), .REP (REP),
      .CNT_W (CNT_W), .FRAME_W (FRAME_W), .ODD_PAR (ODD_PAR)
   ) u_build (
      .hit_count_i (hit_count_i),
      .h0_time_i   (hit0_time_i),
      .h0_pos_i    (hit0_pos_i),
      .h1_time_i   (hit1_time_i),
      .h1_pos_i    (hit1_pos_i),
      .frame_o     (frame_d),
      .ovf_o       (ovf_d)
   );

   trig_lane_ser #(.FRAME_W(FRAME_W), .LANE_W(LANE_W)) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (boundary),
      .frame_i (frame_d),
      .lane_o  (ser_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= '0;
         valid_q <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         valid_q <= boundary;
         if (boundary) begin
            frame_q <= frame_d;
            ovf_q   <= ovf_d;
         end
      end
   end

   assign frame_o       = frame_q;
   assign frame_valid_o = valid_q;
   assign overflow_o    = ovf_q;
endmodule

// File: rtl/trig_hit_packer_chk.sv
module trig_hit_packer_chk #(
   parameter int unsigned FRAME_W   = 24,
   parameter int unsigned LANE_W    = 8,
   parameter int unsigned FRAME_CYC = 3,
   parameter int unsigned REP       = 3,
   parameter int unsigned CNT_W     = 3,
   parameter int unsigned HIT_W     = 7,
   parameter bit          ODD_PAR   = 1'b0,
   localparam int unsigned GW       = trig_pack_pkg::tp_clog2(FRAME_CYC + 1) + 1,
   localparam int unsigned S0_HI    = FRAME_W - REP - 1,
   localparam int unsigned S1_HI    = S0_HI - HIT_W,
   localparam int unsigned PAR_BIT  = S1_HI - HIT_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic [CNT_W-1:0]   hit_count_i,
   input logic [FRAME_W-1:0] frame_o,
   input logic               frame_valid_o,
   input logic               overflow_o,
   input logic [LANE_W-1:0]  ser_o
);
   logic [GW-1:0] gap_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             gap_q <= '0;
      else if (frame_valid_o) gap_q <= GW'(1);
      else                    gap_q <= gap_q + 1'b1;
   end

   p_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid_o |-> (gap_q == GW'(FRAME_CYC)));
   p_period_due_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_q == GW'(FRAME_CYC)) |-> frame_valid_o);
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid_o |-> $stable(frame_o) && $stable(overflow_o));
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid_o |-> (overflow_o == ($past(hit_count_i) > CNT_W'(2))));
   p_desc_rep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid_o |-> ($countones(frame_o[FRAME_W-1 -: REP]) == 0 ||
                         $countones(frame_o[FRAME_W-1 -: REP]) == REP));
   p_slot1_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid_o && !frame_o[FRAME_W-1]) |-> (frame_o[S1_HI -: HIT_W] == '0));
   p_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid_o |-> ((^frame_o[S0_HI:PAR_BIT]) == ODD_PAR));
   p_lane_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid_o |-> (ser_o == frame_o[FRAME_W-1 -: LANE_W]));
   p_lane_second_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid_o |=> (ser_o == $past(frame_o[FRAME_W-LANE_W-1 -: LANE_W])));
endmodule

bind trig_hit_packer trig_hit_packer_chk #(
   .FRAME_W (FRAME_W), .LANE_W (LANE_W), .FRAME_CYC (FRAME_CYC),
   .REP (REP), .CNT_W (CNT_W), .HIT_W (HIT_W), .ODD_PAR (ODD_PAR)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .hit_count_i   (hit_count_i),
   .frame_o       (frame_o),
   .frame_valid_o (frame_valid_o),
   .overflow_o    (overflow_o),
   .ser_o         (ser_o)
);

// File: tb/trig_hit_packer_tb.sv
module trig_hit_packer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  hc = '0;
   logic [1:0]  t0 = '0, t1 = '0;
   logic [4:0]  p0 = '0, p1 = '0;
   logic [23:0] frame;
   logic        fvalid, ovf;
   logic [7:0]  ser;
   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   trig_hit_packer u_dut (
      .clk (clk), .rst_n (rst_n), .hit_count_i (hc),
      .hit0_time_i (t0), .hit0_pos_i (p0),
      .hit1_time_i (t1), .hit1_pos_i (p1),
      .frame_o (frame), .frame_valid_o (fvalid),
      .overflow_o (ovf), .ser_o (ser)
   );

   // {count[2:0], t0[1:0], p0[4:0], t1[1:0], p1[4:0]}
   localparam int NV = 9;
   localparam logic [16:0] VEC [NV] = '{
      {3'd0, 2'd3, 5'd31, 2'd3, 5'd31},
      {3'd1, 2'd2, 5'h15, 2'd1, 5'h0A},
      {3'd2, 2'd1, 5'h05, 2'd3, 5'h1F},
      {3'd3, 2'd0, 5'h11, 2'd2, 5'h03},
      {3'd7, 2'd3, 5'h1E, 2'd1, 5'h01},
      {3'd2, 2'd0, 5'h00, 2'd0, 5'h00},
      {3'd1, 2'd3, 5'h1F, 2'd0, 5'h00},
      {3'd2, 2'd1, 5'h00, 2'd0, 5'h01},
      {3'd0, 2'd0, 5'h00, 2'd0, 5'h00}
   };

   function automatic logic [23:0] expect_frame(input logic [16:0] v);
      logic [23:0] f;
      logic two, one;
      f   = '0;
      two = v[16:14] >= 3'd2;
      one = v[16:14] != 3'd0;
      f[23:21] = {3{two}};                       // R4
      if (one) f[20:14] = v[13:7];               // R5
      if (two) f[13:7]  = v[6:0];                // R5, R6
      f[6] = ^f[20:7];                           // R7
      f[5] = one;                                // R8
      return f;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [16:0] v);
      {hc, t0, p0, t1, p1} = v;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [23:0] e;
      logic [23:0] held;
      repeat (3) @(posedge clk);
      #1;
      chk("R10 frame in reset", 32'(frame), 0);
      chk("R10 valid in reset", 32'(fvalid), 0);
      chk("R10 ovf in reset", 32'(ovf), 0);
      chk("R10 ser in reset", 32'(ser), 0);
      rst_n = 1'b1;
      @(posedge clk); #1 chk("R1 no pulse after edge1", 32'(fvalid), 0);
      @(posedge clk); #1 chk("R1 no pulse after edge2", 32'(fvalid), 0);
      for (int i = 0; i < NV; i++) begin
         apply(VEC[i]);
         e = expect_frame(VEC[i]);
         @(posedge clk); #1;
         chk("R1 pulse at boundary", 32'(fvalid), 1);
         chk("R4 R5 R6 R7 R8 frame", 32'(frame), 32'(e));
         chk("R3 overflow", 32'(ovf), 32'(VEC[i][16:14] > 3'd2));
         chk("R9 byte 2", 32'(ser), 32'(e[23:16]));
         held = frame;
         {hc, t0, p0, t1, p1} = '1;              // junk between boundaries
         @(posedge clk); #1;
         chk("R1 pulse one cycle", 32'(fvalid), 0);
         chk("R2 frame held", 32'(frame), 32'(held));
         chk("R2 R3 ovf held", 32'(ovf), 32'(VEC[i][16:14] > 3'd2));
         chk("R9 byte 1", 32'(ser), 32'(e[15:8]));
         @(posedge clk); #1;
         chk("R1 no pulse", 32'(fvalid), 0);
         chk("R9 byte 0", 32'(ser), 32'(e[7:0]));
         chk("R2 frame held 2", 32'(frame), 32'(held));
      end
      // R10: reset mid-window restarts the phase
      @(posedge clk); #1;
      rst_n = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      chk("R10 frame cleared", 32'(frame), 0);
      chk("R10 ser cleared", 32'(ser), 0);
      chk("R10 valid cleared", 32'(fvalid), 0);
      rst_n = 1'b1;
      apply(VEC[2]);
      @(posedge clk); #1 chk("R10 R1 no pulse e1", 32'(fvalid), 0);
      @(posedge clk); #1 chk("R10 R1 no pulse e2", 32'(fvalid), 0);
      @(posedge clk); #1;
      chk("R10 R1 pulse e3", 32'(fvalid), 1);
      chk("R10 frame after restart", 32'(frame), 32'(expect_frame(VEC[2])));
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule